// File: doc/BRIEF.md
# Two-Key Register Write-Protection Lock

This block keeps a group of protected configuration registers from being changed by stray writes. Software opens the lock by writing two byte keys, one after the other, to a dedicated key register. The first key is 0xCA and the second is 0x53. Any other value written to the key register closes the lock again. While the lock is closed, the block masks each protected register's write strobe. A masked write is dropped without any error.

The lock state is held in flops on the backup-domain reset only. A system reset does not touch it. While the system reset is asserted, the key register and the protected registers accept no writes. An outer domain-access enable must also be high before any write is accepted, and that includes key writes.

The protected set is chosen by which register write strobes are routed through the gate. That choice is made outside the lock logic.

Top module: `wp_lock`

## Requirements
- R1: While the backup-domain reset is asserted, and after it is released, the lock is closed: `unlocked` is 0 and every bit of `prot_wr_en` is 0.
- R2: An accepted key write of 0xCA, followed by an accepted key write of 0x53, opens the lock. `unlocked` goes to 1 in the cycle after the 0x53 write. Idle cycles between the two key writes do not cancel the sequence.
- R3: An accepted key write of any value other than 0xCA closes the lock from any state. This includes 0x53 written while the lock is closed or already open. `unlocked` is 0 in the cycle after the write.
- R4: An accepted key write of 0xCA in any state restarts the sequence at the first-key-seen step. If the lock was open, it is closed after the write, and a following 0x53 opens it again.
- R5: `prot_wr_en[i]` equals `prot_wr_req[i]` in the same cycle only when all three conditions hold: `unlocked` is 1, `dom_access_en` is 1 and `sys_rst_n` is 1. Otherwise `prot_wr_en` is all zero, and the dropped write raises no other output.
- R6: A key write made while `dom_access_en` is 0 is ignored. It leaves the lock state, and any sequence in progress, unchanged.
- R7: Asserting `sys_rst_n` (low) does not change the lock state. Key writes made while it is low are ignored.
- R8: `key_rdata`, the read value of the key register, is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bkp_rst_n | input | 1 | Backup-domain reset, active low, asserted asynchronously and released synchronously |
| sys_rst_n | input | 1 | System reset, active low; while it is low, writes are blocked and the lock state is kept |
| dom_access_en | input | 1 | Outer domain-access enable; every write is refused while it is low |
| key_wr | input | 1 | Write strobe for the key register |
| key_wdata | input | KEY_W | Data written to the key register |
| key_rdata | output | KEY_W | Read value of the key register, always zero |
| prot_wr_req | input | NREG | Write strobes of the protected registers, one per register |
| prot_wr_en | output | NREG | Gated write enables of the protected registers |
| unlocked | output | 1 | 1 while the lock is open |

## Verification
The bench targets each of the following cases and states how a faulty design would show it:
- **0x53 written twice.** This is 0x53 written while closed, and 0x53 written again while already open. A design that treated the second key as a no-op would stay open.
- **0xCA written while open.** A design that treated 0xCA as a wrong key could never resume at the second step. A design that ignored 0xCA here would stay open.
- **Refused writes between the two keys.** These are writes made with the access enable low or with the system reset asserted. A design that let such writes reach the sequence logic would lose or corrupt the sequence. A design that cleared the lock on system reset would drop `unlocked`.
- **Gating in the cycle a condition changes.** A design that registered the gate, or ignored one of the three conditions, would let a write through one cycle late or while refused.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;
  typedef enum logic [1:0] {
    WP_LOCKED = 2'd0,
    WP_ARMED  = 2'd1,
    WP_OPEN   = 2'd2
  } wp_state_e;
endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/wp_key_fsm.sv
module wp_key_fsm
  import wp_lock_pkg::*;
#(
  parameter int              KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'h53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [KEY_W-1:0] wdata,
  output wp_state_e        state_o,
  output logic             unlocked_o
);
  wp_state_e state_q, state_d;
  logic      state_en;

  // a transition is evaluated only on an accepted key write
  assign state_en = accept;

  always_comb begin
    state_d = state_q;
    if (wdata == KEY_FIRST)                                state_d = WP_ARMED;
    else if (state_q == WP_ARMED && wdata == KEY_SECOND)   state_d = WP_OPEN;
    else                                                   state_d = WP_LOCKED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= WP_LOCKED;
    else if (state_en) state_q <= state_d;
  end

  assign state_o    = state_q;
  assign unlocked_o = (state_q == WP_OPEN);
endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate #(
  parameter int NREG = 6
) (
  input  logic            allow,
  input  logic [NREG-1:0] req,
  output logic [NREG-1:0] en
);
  for (genvar i = 0; i < NREG; i++) begin : g_gate
    assign en[i] = req[i] & allow;
  end
endmodule

// File: rtl/wp_lock.sv
module wp_lock
  import wp_lock_pkg::*;
#(
  parameter int              NREG       = 6,
  parameter int              KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'h53,
  parameter int              SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             bkp_rst_n,
  input  logic             sys_rst_n,
  input  logic             dom_access_en,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_wdata,
  output logic [KEY_W-1:0] key_rdata,
  input  logic [NREG-1:0]  prot_wr_req,
  output logic [NREG-1:0]  prot_wr_en,
  output logic             unlocked
);
  logic      rst_sync_n;
  logic      wr_allowed;
  logic      key_accept;
  wp_state_e state_q;

  assign wr_allowed = dom_access_en & sys_rst_n;
  assign key_accept = key_wr & wr_allowed;
  assign key_rdata  = '0;

  wp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (bkp_rst_n),
    .rst_n_o (rst_sync_n)
  );

  wp_key_fsm #(
    .KEY_W      (KEY_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (key_accept),
    .wdata      (key_wdata),
    .state_o    (state_q),
    .unlocked_o (unlocked)
  );

  wp_write_gate #(.NREG(NREG)) u_gate (
    .allow (unlocked & wr_allowed),
    .req   (prot_wr_req),
    .en    (prot_wr_en)
  );
endmodule

// File: rtl/wp_lock_chk.sv
module wp_lock_chk
  import wp_lock_pkg::*;
#(
  parameter int              NREG       = 6,
  parameter int              KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'h53
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_rst_n,
  input logic             dom_access_en,
  input logic             key_wr,
  input logic [KEY_W-1:0] key_wdata,
  input logic [NREG-1:0]  prot_wr_en,
  input logic             unlocked,
  input wp_state_e        state_q
);
  logic acc;
  assign acc = key_wr & dom_access_en & sys_rst_n;

  p_second_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && state_q == WP_ARMED && key_wdata == KEY_SECOND) |=> unlocked);

  p_wrong_key_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && key_wdata != KEY_FIRST && !(state_q == WP_ARMED && key_wdata == KEY_SECOND))
    |=> (state_q == WP_LOCKED));

  p_first_key_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && key_wdata == KEY_FIRST) |=> (state_q == WP_ARMED));

  p_closed_gates_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (prot_wr_en == '0));

  p_refused_gates_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dom_access_en && sys_rst_n) |-> (prot_wr_en == '0));

  p_refused_key_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !dom_access_en) |=> $stable(state_q));

  p_sysrst_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |=> $stable(state_q));
endmodule

bind wp_lock wp_lock_chk #(
  .NREG(NREG), .KEY_W(KEY_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .sys_rst_n     (sys_rst_n),
  .dom_access_en (dom_access_en),
  .key_wr        (key_wr),
  .key_wdata     (key_wdata),
  .prot_wr_en    (prot_wr_en),
  .unlocked      (unlocked),
  .state_q       (state_q)
);

// File: tb/wp_lock_bench.sv
`timescale 1ns/1ps
module wp_lock_bench;
  localparam int NREG  = 6;
  localparam int KEY_W = 8;

  logic             clk;
  logic             bkp_rst_n, sys_rst_n, dom_access_en, key_wr;
  logic [KEY_W-1:0] key_wdata;
  logic [KEY_W-1:0] key_rdata;
  logic [NREG-1:0]  prot_wr_req, prot_wr_en;
  logic             unlocked;

  int checks = 0;
  int failures = 0;
  int mstate = 0;        // 0 closed, 1 first key seen, 2 open
  string last_tag = "R1";
  bit done = 0;

  wp_lock u_wp_lock (
    .clk(clk), .bkp_rst_n(bkp_rst_n), .sys_rst_n(sys_rst_n),
    .dom_access_en(dom_access_en), .key_wr(key_wr), .key_wdata(key_wdata),
    .key_rdata(key_rdata), .prot_wr_req(prot_wr_req), .prot_wr_en(prot_wr_en),
    .unlocked(unlocked)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int next_state(int s, bit wr, logic [7:0] d, bit dae, bit sr);
    if (!(wr && dae && sr)) return s;
    if (d == 8'hCA) return 1;
    if (s == 1 && d == 8'h53) return 2;
    return 0;
  endfunction

  function automatic logic [NREG-1:0] exp_gate(int s, bit dae, bit sr, logic [NREG-1:0] r);
    return (s == 2 && dae && sr) ? r : '0;
  endfunction

  task automatic check_bits(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, check outputs, update model at posedge
  task automatic cyc(bit wr, logic [7:0] d, bit dae, bit sr, logic [NREG-1:0] r, string tag);
    @(negedge clk);
    check_bits(last_tag, {31'd0, unlocked}, {31'd0, mstate == 2});
    key_wr = wr; key_wdata = d; dom_access_en = dae; sys_rst_n = sr; prot_wr_req = r;
    #1;
    check_bits("R5", {26'd0, prot_wr_en}, {26'd0, exp_gate(mstate, dae, sr, r)});
    check_bits("R8", {24'd0, key_rdata}, 32'd0);
    @(posedge clk);
    mstate = next_state(mstate, wr, d, dae, sr);
    last_tag = tag;
  endtask

  task automatic key(logic [7:0] d, string tag);
    cyc(1, d, 1, 1, '1, tag);
  endtask

  task automatic idle(string tag);
    cyc(0, 8'h00, 1, 1, '1, tag);
  endtask

  task automatic do_bkp_reset();
    @(negedge clk);
    bkp_rst_n = 0; key_wr = 0; prot_wr_req = '1; dom_access_en = 1; sys_rst_n = 1;
    #1;
    mstate = 0;
    check_bits("R1", {31'd0, unlocked}, 32'd0);
    check_bits("R1", {26'd0, prot_wr_en}, 32'd0);
    repeat (2) @(negedge clk);
    bkp_rst_n = 1;
    repeat (3) @(negedge clk);
    last_tag = "R1";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    bkp_rst_n = 0; sys_rst_n = 1; dom_access_en = 1; key_wr = 0;
    key_wdata = 0; prot_wr_req = 0;
    do_bkp_reset();
    idle("R1");

    // R2 basic unlock with idle gap
    key(8'hCA, "R2"); idle("R2"); idle("R2"); key(8'h53, "R2"); idle("R2");
    // R3 second key while open closes
    key(8'h53, "R3"); idle("R3");
    // R3 second key while closed stays closed
    key(8'h53, "R3"); idle("R3");
    // R4 first key while open restarts
    key(8'hCA, "R2"); key(8'h53, "R2"); key(8'hCA, "R4"); idle("R4");
    key(8'h53, "R4"); idle("R4");
    // R4 repeated first key
    key(8'hCA, "R4"); key(8'hCA, "R4"); key(8'h53, "R4"); idle("R4");
    // R3 other wrong value
    key(8'h00, "R3"); idle("R3");
    // R6 refused write mid-sequence keeps progress
    key(8'hCA, "R6"); cyc(1, 8'h11, 0, 1, '1, "R6"); key(8'h53, "R6"); idle("R6");
    cyc(1, 8'h00, 0, 1, '1, "R6"); idle("R6");
    // R7 system reset keeps state and blocks writes
    cyc(1, 8'h00, 1, 0, '1, "R7"); cyc(0, 8'h00, 1, 0, '1, "R7"); idle("R7");
    key(8'h00, "R3"); key(8'hCA, "R7"); cyc(1, 8'h53, 1, 0, '1, "R7");
    idle("R7"); key(8'h53, "R7"); idle("R7");
    // R1 backup reset while open
    do_bkp_reset();
    idle("R1");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int pick = $urandom_range(0, 9);
      logic [7:0] d = (pick < 4) ? 8'hCA : (pick < 8) ? 8'h53 : 8'($urandom);
      bit wr  = ($urandom_range(0, 2) != 0);
      bit dae = ($urandom_range(0, 9) != 0);
      bit sr  = ($urandom_range(0, 19) != 0);
      cyc(wr, d, dae, sr, NREG'($urandom), (!dae) ? "R6" : (!sr) ? "R7" : "R3");
    end
    idle("R3");
    @(negedge clk);
    check_bits(last_tag, {31'd0, unlocked}, {31'd0, mstate == 2});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule